// File: doc/BRIEF.md
# Alternating Two-Slot Receive Buffer Controller

This block takes packets from a word stream and parks each one in one of two fixed slots ("ping" and "pong") of an internal dual-port memory, so software can drain one slot while the next packet lands in the other. Each slot has a full flag. The hardware raises the flag when a packet has been stored completely. Software lowers it with a register write once it has read the data. The slot choice flips after every packet, whatever became of that packet. A packet whose slot is still flagged full is thrown away and is not redirected.

A parameter reduces the block to one slot. In that mode every packet targets ping, and packets that arrive while ping is full are discarded. Software reaches the flags, an interrupt-enable bit and both slots through one word-addressed read/write port. A gated single-cycle interrupt marks every stored packet.

Top module: `rxpp_ctrl`

## Requirements
- R1: After reset both full flags are 0, the interrupt enable is 0, `irq` is low and the first packet targets ping.
- R2: Memory map, with byte address = 4 × `sw_addr`. Word 0 (byte 0x000) bit 0 is the ping full flag. Word 1 (0x004) bit 0 is the pong full flag. Word 2 (0x008) bit 0 is the interrupt enable. Ping word i sits at byte 0x1000+4i (0x1000–0x17FC). Pong word i sits at 0x1800+4i (0x1800–0x1FFC). A read returns on `sw_rdata` one clock after `sw_addr` is presented, and unused register bits read 0.
- R3: In two-slot mode the target slot alternates ping, pong, ping, … and flips at the end of every packet, including dropped and errored ones.
- R4: A packet that ends without error in a free slot sets that slot's full flag in the cycle after its last beat.
- R5: Writing 0 (`sw_wbit`=0) to a flag word clears that flag and frees the slot. Writing 1 leaves the flag unchanged.
- R6: A packet whose target slot is full at its first beat is discarded. The slot's data stays unchanged, its flag stays set and no interrupt is raised.
- R7: `irq` is a one-cycle pulse in the cycle after the last beat of each stored packet, and only while the interrupt enable is 1.
- R8: A packet whose last beat carries `s_err`=1 does not set a flag and raises no interrupt, but the slot pointer still flips.
- R9: With `DUAL_BUF`=0 every packet targets ping, the pong flag never sets, and packets that arrive while ping is full are discarded.
- R10: A packet longer than 512 words stores its first 512 words, and word 511 is the last one kept. The other slot is not written, and the flag is set on the last beat as for a normal packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Stream beat valid (no back-pressure) |
| s_data | input | 32 | Stream data word |
| s_last | input | 1 | Last beat of packet |
| s_err | input | 1 | Packet errored/aborted, qualified with s_last |
| sw_addr | input | 11 | Software word address (byte address / 4) |
| sw_wr | input | 1 | Software register write strobe |
| sw_wbit | input | 1 | Software write data bit 0 |
| sw_rdata | output | 32 | Read data, one cycle after sw_addr |
| irq | output | 1 | Receive-complete pulse |

## Verification
The assertions take it for granted that a stream beat only counts as valid when `s_valid` is high, and that a packet always ends with `s_last`. Under that assumption, a slot that is being written stays free until that same packet ends. The stimulus always sends whole packets and leaves idle cycles between them. It changes flags and enables only between packets, so the decision to drop a packet is always made against a settled flag.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
    localparam int DATA_W    = 32;
    localparam int BUF_WORDS = 512;
    localparam int WORD_AW   = $clog2(BUF_WORDS);
    localparam int BSEL_BIT  = WORD_AW;       // word-address bit picking the slot
    localparam int MEM_BIT   = WORD_AW + 1;   // word-address bit picking memory space
    localparam int SWA_W     = WORD_AW + 2;

    typedef enum logic {BUF_PING = 1'b0, BUF_PONG = 1'b1} buf_e;

    typedef struct packed {
        logic               we;
        buf_e               bsel;
        logic [WORD_AW-1:0] widx;
        logic [DATA_W-1:0]  wdata;
    } memwr_t;

    typedef struct packed {
        logic valid;
        logic good;
        buf_e bsel;
    } pktend_t;

    localparam logic [1:0] REG_PING_ST = 2'd0;
    localparam logic [1:0] REG_PONG_ST = 2'd1;
    localparam logic [1:0] REG_IRQ_EN  = 2'd2;

    function automatic buf_e flip_buf(buf_e b);
        return (b == BUF_PING) ? BUF_PONG : BUF_PING;
    endfunction
endpackage

// File: rtl/rxpp_capture.sv
module rxpp_capture
    import rxpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_err,
    input  buf_e              ptr,
    input  logic [1:0]        full,
    output memwr_t            wr,
    output pktend_t           pend
);
    logic             in_pkt;
    logic             cur_drop;
    buf_e             cur_buf;
    logic [WORD_AW:0] cnt;     // top bit set once the slot is exhausted

    logic first;
    buf_e tgt;
    logic drop;

    always_comb begin
        first      = s_valid && !in_pkt;
        tgt        = first ? ptr : cur_buf;
        drop       = first ? full[ptr] : cur_drop;
        wr.we      = s_valid && !drop && !cnt[WORD_AW];
        wr.bsel    = tgt;
        wr.widx    = cnt[WORD_AW-1:0];
        wr.wdata   = s_data;
        pend.valid = s_valid && s_last;
        pend.good  = !drop && !s_err;
        pend.bsel  = tgt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt   <= 1'b0;
            cur_drop <= 1'b0;
            cur_buf  <= BUF_PING;
            cnt      <= '0;
        end else if (s_valid) begin
            if (s_last) begin
                in_pkt <= 1'b0;
                cnt    <= '0;
            end else begin
                in_pkt   <= 1'b1;
                cur_buf  <= tgt;
                cur_drop <= drop;
                if (!cnt[WORD_AW]) cnt <= cnt + 1'b1;
            end
        end
    end

    AST_NO_WR_TO_FULL: assert property (@(posedge clk) disable iff (rst)
        wr.we |-> !full[wr.bsel]); // R6
    AST_TRUNC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (s_valid && !s_last && cnt[WORD_AW]) |=> !wr.we || !s_valid || cnt == '0); // R10
endmodule

// File: rtl/rxpp_steer.sv
module rxpp_steer
    import rxpp_pkg::*;
#(
    parameter bit DUAL_BUF = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  pktend_t    pend,
    input  logic [1:0] clr,
    input  logic       irq_en,
    output buf_e       ptr,
    output logic [1:0] full,
    output logic       irq
);
    logic stored;
    assign stored = pend.valid && pend.good;

    generate
        if (DUAL_BUF) begin : g_alt
            buf_e ptr_q;
            always_ff @(posedge clk) begin
                if (rst)             ptr_q <= BUF_PING;
                else if (pend.valid) ptr_q <= flip_buf(ptr_q);
            end
            assign ptr = ptr_q;
            AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (rst)
                pend.valid |=> ptr != $past(ptr)); // R3
        end else begin : g_single
            assign ptr = BUF_PING;
        end
    endgenerate

    for (genvar i = 0; i < 2; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                                      full[i] <= 1'b0;
            else if (stored && pend.bsel == buf_e'(1'(i))) full[i] <= 1'b1;
            else if (clr[i])                              full[i] <= 1'b0;
        end
        AST_FLAG_ONLY_ON_END: assert property (@(posedge clk) disable iff (rst)
            $rose(full[i]) |-> $past(stored)); // R4
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= stored && irq_en;
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(irq_en)); // R7
endmodule

// File: rtl/rxpp_mem.sv
module rxpp_mem
    import rxpp_pkg::*;
(
    input  logic               clk,
    input  memwr_t             wr,
    input  logic [WORD_AW:0]   raddr,
    output logic [DATA_W-1:0]  rdata
);
    localparam int DEPTH = 2 * BUF_WORDS;
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr.we) mem[{wr.bsel, wr.widx}] <= wr.wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl
    import rxpp_pkg::*;
#(
    parameter bit DUAL_BUF = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_err,
    input  logic [SWA_W-1:0]  sw_addr,
    input  logic              sw_wr,
    input  logic              sw_wbit,
    output logic [DATA_W-1:0] sw_rdata,
    output logic              irq
);
    memwr_t            wr;
    pktend_t           pend;
    buf_e              ptr;
    logic [1:0]        full;
    logic [1:0]        clr;
    logic              irq_en;
    logic              reg_wr;
    logic [DATA_W-1:0] mem_q;
    logic [DATA_W-1:0] reg_q;
    logic              sel_mem_q;

    assign reg_wr = sw_wr && !sw_addr[MEM_BIT];
    assign clr[0] = reg_wr && sw_addr[1:0] == REG_PING_ST && !sw_wbit;
    assign clr[1] = reg_wr && sw_addr[1:0] == REG_PONG_ST && !sw_wbit;

    always_ff @(posedge clk) begin
        if (rst)                                     irq_en <= 1'b0;
        else if (reg_wr && sw_addr[1:0] == REG_IRQ_EN) irq_en <= sw_wbit;
    end

    rxpp_capture u_cap (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .s_err(s_err), .ptr(ptr), .full(full),
        .wr(wr), .pend(pend)
    );

    rxpp_steer #(.DUAL_BUF(DUAL_BUF)) u_steer (
        .clk(clk), .rst(rst), .pend(pend), .clr(clr), .irq_en(irq_en),
        .ptr(ptr), .full(full), .irq(irq)
    );

    rxpp_mem u_mem (
        .clk(clk), .wr(wr), .raddr(sw_addr[WORD_AW:0]), .rdata(mem_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q     <= '0;
            sel_mem_q <= 1'b0;
        end else begin
            sel_mem_q <= sw_addr[MEM_BIT];
            unique case (sw_addr[1:0])
                REG_PING_ST: reg_q <= {{(DATA_W-1){1'b0}}, full[0]};
                REG_PONG_ST: reg_q <= {{(DATA_W-1){1'b0}}, full[1]};
                REG_IRQ_EN:  reg_q <= {{(DATA_W-1){1'b0}}, irq_en};
                default:     reg_q <= '0;
            endcase
        end
    end

    assign sw_rdata = sel_mem_q ? mem_q : reg_q;

    generate
        if (!DUAL_BUF) begin : g_single_chk
            AST_SINGLE_PING_ONLY: assert property (@(posedge clk) disable iff (rst)
                wr.we |-> wr.bsel == BUF_PING); // R9
            AST_SINGLE_PONG_IDLE: assert property (@(posedge clk) disable iff (rst)
                !full[1]); // R9
        end
    endgenerate
endmodule

// File: tb/rxpp_ctrl_tb.sv
`timescale 1ns/1ps
module rxpp_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        s_valid, s_last, s_err;
    logic [31:0] s_data;
    logic [10:0] sw_addr;
    logic        sw_wr, sw_wbit;
    logic [31:0] rdata, rdata_sb;
    logic        irq, irq_sb;

    int tests = 0, fails = 0, cycles = 0;
    int irq_cnt = 0, irq_long = 0;
    logic irq_prev = 1'b0;

    always #4 clk = ~clk;

    rxpp_ctrl #(.DUAL_BUF(1'b1)) u_dut (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_err(s_err), .sw_addr(sw_addr), .sw_wr(sw_wr), .sw_wbit(sw_wbit),
        .sw_rdata(rdata), .irq(irq));

    rxpp_ctrl #(.DUAL_BUF(1'b0)) u_dut_sb (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_err(s_err), .sw_addr(sw_addr), .sw_wr(sw_wr), .sw_wbit(sw_wbit),
        .sw_rdata(rdata_sb), .irq(irq_sb));

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (irq && irq_prev) irq_long++;
        irq_prev = irq;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Table fields: clr[15:14] len[13:4] err[3] buf[2] stored[1] flag[0]
    localparam int NV = 7;
    localparam logic [15:0] VEC [NV] = '{
        {2'b00, 10'd3, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'b00, 10'd2, 1'b0, 1'b1, 1'b1, 1'b1},
        {2'b10, 10'd1, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'b00, 10'd4, 1'b0, 1'b1, 1'b1, 1'b1},
        {2'b11, 10'd2, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'b00, 10'd5, 1'b0, 1'b1, 1'b1, 1'b1},
        {2'b00, 10'd1, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    function automatic logic [31:0] pat(int v, int k);
        return 32'hC000_0000 | (32'(v) << 16) | 32'(k);
    endfunction

    function automatic logic [10:0] waddr(bit pong, int k);
        return {1'b1, pong, 9'(k)};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; s_valid = 0; s_last = 0; s_err = 0; s_data = 0;
        sw_wr = 0; sw_wbit = 0; sw_addr = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(logic [10:0] a, output logic [31:0] d, output logic [31:0] dsb);
        @(negedge clk); sw_addr = a;
        @(negedge clk); d = rdata; dsb = rdata_sb;
    endtask

    task automatic wrreg(logic [10:0] a, logic b);
        @(negedge clk); sw_addr = a; sw_wr = 1'b1; sw_wbit = b;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic send(int v, int len, bit err);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = pat(v, k);
            s_last = (k == len - 1); s_err = err && (k == len - 1);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] d, dsb, saved;
        int base;
        do_reset();

        // R1 reset state
        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
        rd(11'd0, d, dsb); check(d == 0, "R1 ping flag reset", d, 0);
        rd(11'd1, d, dsb); check(d == 0, "R1 pong flag reset", d, 0);
        rd(11'd2, d, dsb); check(d == 0, "R1 irq enable reset", d, 0);

        // R5 writing 1 leaves a flag untouched
        wrreg(11'd0, 1'b1);
        rd(11'd0, d, dsb); check(d == 0, "R5 write 1 ignored", d, 0);
        // R2 enable register readback
        wrreg(11'd2, 1'b1);
        rd(11'd2, d, dsb); check(d == 1, "R2 irq enable readback", d, 1);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [1:0] clr; int len; bit err, bsel, st, fl;
            clr = VEC[v][15:14]; len = int'(VEC[v][13:4]); err = VEC[v][3];
            bsel = VEC[v][2]; st = VEC[v][1]; fl = VEC[v][0];
            if (clr[0]) wrreg(11'd0, 1'b0);
            if (clr[1]) wrreg(11'd1, 1'b0);
            base = irq_cnt;
            send(v, len, err);
            @(negedge clk);
            check(irq_cnt - base == int'(st), $sformatf("R7 irq count vec%0d", v),
                  32'(irq_cnt - base), 32'(st));
            rd({10'd0, bsel}, d, dsb);
            check(d == 32'(fl), $sformatf("R4/R6/R8 flag vec%0d", v), d, 32'(fl));
            rd(waddr(bsel, 0), d, dsb);
            if (st) begin
                check(d == pat(v, 0), $sformatf("R2/R3 first word vec%0d", v), d, pat(v, 0));
                rd(waddr(bsel, len - 1), d, dsb);
                check(d == pat(v, len - 1), $sformatf("R2 last word vec%0d", v), d, pat(v, len - 1));
            end else if (fl) begin
                check(d != pat(v, 0), $sformatf("R6 dropped data vec%0d", v), d, ~pat(v, 0));
            end
        end
        check(irq_long == 0, "R7 irq single cycle", 32'(irq_long), 0);

        // R7 enable off, R9 single-slot mode
        do_reset();
        base = irq_cnt;
        send(20, 2, 1'b0);
        @(negedge clk);
        check(irq_cnt == base, "R7 no irq when disabled", 32'(irq_cnt - base), 0);
        rd(11'd0, d, dsb);
        check(d == 1, "R4 ping flag with irq off", d, 1);
        check(dsb == 1, "R9 single ping flag", dsb, 1);
        send(21, 2, 1'b0);
        rd(11'd1, d, dsb);
        check(d == 1, "R3 second packet to pong", d, 1);
        check(dsb == 0, "R9 single pong flag stays 0", dsb, 0);
        rd(waddr(0, 0), d, dsb);
        check(dsb == pat(20, 0), "R9 single dropped while full", dsb, pat(20, 0));

        // R10 truncation
        do_reset();
        wrreg(11'd2, 1'b1);
        rd(waddr(1, 0), saved, dsb);
        base = irq_cnt;
        send(30, 520, 1'b0);
        @(negedge clk);
        check(irq_cnt - base == 1, "R10 irq on long packet", 32'(irq_cnt - base), 1);
        rd(11'd0, d, dsb); check(d == 1, "R10 flag set on long packet", d, 1);
        rd(waddr(0, 511), d, dsb);
        check(d == pat(30, 511), "R10 last kept word", d, pat(30, 511));
        rd(waddr(0, 0), d, dsb);
        check(d == pat(30, 0), "R10 first word", d, pat(30, 0));
        rd(waddr(1, 0), d, dsb);
        check(d == saved, "R10 pong untouched", d, saved);

        // R5 clear frees the slot for reuse
        wrreg(11'd0, 1'b0);
        rd(11'd0, d, dsb); check(d == 0, "R5 clear ping", d, 0);
        send(31, 1, 1'b0);      // to pong
        send(32, 2, 1'b0);      // to ping again
        rd(11'd0, d, dsb); check(d == 1, "R5 ping refilled", d, 1);
        rd(waddr(0, 1), d, dsb);
        check(d == pat(32, 1), "R3/R5 ping new data", d, pat(32, 1));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule